// File: doc/BRIEF.md
# Integer ALU with shifter flags

This block is the combinational integer execution unit of a 32-bit core. It takes two register operands, an operation code, an immediate-select bit and a 5-bit immediate. In the same cycle it returns a result, a register write strobe, a flag write strobe and four condition flags: zero, sign, overflow and carry.

The second operand (`opB`) is always the destination-side value. It is the augend, the minuend or the value being shifted. The first operand (`opA`) supplies the other input, unless `useImm` routes the immediate in its place. An immediate is sign-extended when it feeds a move, an arithmetic operation or a logical operation. It is taken as an unsigned count when it feeds a shift. The surrounding pipeline writes `result` to the register file when `wrEn` is high, and writes the flags when `flagWe` is high.

Top module: `int_alu`

## Requirements
- R1: ADD gives `opB + src`. Carry is set when the 32-bit sum is unsigned-less-than `opB`. Overflow is set when `opB` and `src` have the same sign and the sum's sign differs from it.
- R2: SUB and CMP give `opB - src`. Carry is set when that difference is unsigned-greater-than `opB`. Overflow is set when the two inputs differ in sign and the difference's sign differs from `opB`'s sign.
- R3: CMP drives all four flags with `flagWe` high. It holds `wrEn` low and drives the difference on `result`.
- R4: When a shift count comes from `opA`, only `opA[4:0]` is used. The upper 27 bits have no effect on the outputs.
- R5: For SHL by n, carry is bit (32-n) of `opB`. For SHR and SAR by n, carry is bit (n-1) of `opB`. A count of zero gives carry 0 and leaves the result equal to `opB`.
- R6: SHL, SHR, SAR, AND, OR, XOR and NOT all give overflow 0.
- R7: SAR fills the vacated upper bits with `opB[31]`. SHR fills them with zeros.
- R8: With `useImm` high, the immediate replaces `opA`. It is sign-extended for MOV, ADD, SUB, CMP and the logical operations. It is zero-extended when used as a shift count.
- R9: MOV writes `src` with `wrEn` high and `flagWe` low. All four flag outputs are 0 while `flagWe` is low.
- R10: For every operation that raises `flagWe`, zero equals (`result` == 0) and sign equals `result[31]`.
- R11: `opSel` encoding: 0 MOV, 1 ADD, 2 SUB, 3 CMP, 4 AND, 5 OR, 6 XOR, 7 NOT (gives `~src`), 8 SHL, 9 SHR, 10 SAR. Codes 11 to 15 drive `result`, `wrEn`, `flagWe` and every flag to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code (see R11) |
| opA | input | 32 | Source operand or register shift count |
| opB | input | 32 | Destination-side operand |
| useImm | input | 1 | Use the immediate in place of `opA` |
| imm | input | 5 | Immediate field |
| result | output | 32 | Operation result |
| wrEn | output | 1 | Register write strobe |
| flagWe | output | 1 | Flag write strobe |
| zeroFlag | output | 1 | Result is zero |
| signFlag | output | 1 | Result bit 31 |
| ovfFlag | output | 1 | Signed overflow |
| carryFlag | output | 1 | Carry, borrow or shifted-out bit |

## Verification
The checker evaluates its assertions only after `opSel`, the operands and the immediate are all known, because an input with unknown bits has no defined flag outcome. The bench changes inputs only on the falling clock edge and reads outputs one time unit later. Every vector the bench drives is therefore fully known and has settled before the outputs are checked. Random operands are also drawn fully known, and each random vector carries an `opSel` from 0 to 15, so the undefined codes are covered too.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [3:0] {
    OP_MOV = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_CMP = 4'd3,
    OP_AND = 4'd4, OP_OR  = 4'd5, OP_XOR = 4'd6, OP_NOT = 4'd7,
    OP_SHL = 4'd8, OP_SHR = 4'd9, OP_SAR = 4'd10
  } opSel_e;

  typedef enum logic [1:0] { LG_AND = 2'd0, LG_OR = 2'd1, LG_XOR = 2'd2, LG_NOT = 2'd3 } logicKind_e;
  typedef enum logic [1:0] { SH_LEFT = 2'd0, SH_RLOG = 2'd1, SH_RARI = 2'd2 } shiftKind_e;

  typedef struct packed {
    logic       selMove;
    logic       selAdd;
    logic       selSub;
    logic       selLogic;
    logicKind_e logicKind;
    logic       selShift;
    shiftKind_e shiftKind;
    logic       wrEn;
    logic       flagWe;
  } aluStrobe_t;
endpackage

// File: rtl/int_alu_ctrl.sv
module int_alu_ctrl
  import int_alu_pkg::*;
(
  input  logic [3:0] opSel,
  output aluStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    case (opSel)
      OP_MOV: begin strobe.selMove = 1'b1; strobe.wrEn = 1'b1; end
      OP_ADD: begin strobe.selAdd = 1'b1; strobe.wrEn = 1'b1; strobe.flagWe = 1'b1; end
      OP_SUB: begin strobe.selSub = 1'b1; strobe.wrEn = 1'b1; strobe.flagWe = 1'b1; end
      OP_CMP: begin strobe.selSub = 1'b1; strobe.flagWe = 1'b1; end
      OP_AND, OP_OR, OP_XOR, OP_NOT: begin
        strobe.selLogic  = 1'b1;
        strobe.logicKind = logicKind_e'(opSel[1:0]);
        strobe.wrEn      = 1'b1;
        strobe.flagWe    = 1'b1;
      end
      OP_SHL, OP_SHR, OP_SAR: begin
        strobe.selShift  = 1'b1;
        strobe.shiftKind = (opSel == OP_SHL) ? SH_LEFT :
                           (opSel == OP_SHR) ? SH_RLOG : SH_RARI;
        strobe.wrEn      = 1'b1;
        strobe.flagWe    = 1'b1;
      end
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/int_alu_dp.sv
module int_alu_dp
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 5
) (
  input  aluStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             useImm,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             signFlag,
  output logic             ovfFlag,
  output logic             carryFlag
);
  localparam int SH_W = $clog2(WIDTH);
  localparam int MSB  = WIDTH - 1;

  logic [WIDTH-1:0] immSext, immZext, src;
  logic [WIDTH-1:0] sumVal, diffVal, logicVal, shiftVal, resVal;
  logic [SH_W-1:0]  shAmt;
  logic [WIDTH:0]   shlExt, shrExt;
  logic             addCy, addOv, subCy, subOv, shCy, ovVal, cyVal;

  assign immSext = {{(WIDTH-IMM_W){imm[IMM_W-1]}}, imm};
  assign immZext = {{(WIDTH-IMM_W){1'b0}}, imm};
  assign src     = !useImm ? opA : (strobe.selShift ? immZext : immSext);

  // adder and subtractor
  assign sumVal  = opB + src;
  assign diffVal = opB - src;
  assign addCy   = sumVal < opB;
  assign subCy   = diffVal > opB;
  assign addOv   = (opB[MSB] == src[MSB]) && (sumVal[MSB] != opB[MSB]);
  assign subOv   = (opB[MSB] != src[MSB]) && (diffVal[MSB] != opB[MSB]);

  // logic unit
  always_comb begin
    case (strobe.logicKind)
      LG_AND:  logicVal = src & opB;
      LG_OR:   logicVal = src | opB;
      LG_XOR:  logicVal = src ^ opB;
      default: logicVal = ~src;
    endcase
  end

  // shifter: the extra bit beyond each end catches the last bit shifted out
  assign shAmt  = src[SH_W-1:0];
  assign shlExt = {1'b0, opB} << shAmt;
  assign shrExt = {opB, 1'b0} >> shAmt;
  always_comb begin
    case (strobe.shiftKind)
      SH_LEFT: begin shiftVal = shlExt[WIDTH-1:0]; shCy = shlExt[WIDTH]; end
      SH_RLOG: begin shiftVal = opB >> shAmt;     shCy = shrExt[0];     end
      default: begin shiftVal = WIDTH'($signed(opB) >>> shAmt); shCy = shrExt[0]; end
    endcase
  end

  always_comb begin
    resVal = '0;
    ovVal  = 1'b0;
    cyVal  = 1'b0;
    if (strobe.selMove)  resVal = src;
    if (strobe.selAdd)   begin resVal = sumVal;  ovVal = addOv; cyVal = addCy; end
    if (strobe.selSub)   begin resVal = diffVal; ovVal = subOv; cyVal = subCy; end
    if (strobe.selLogic) resVal = logicVal;
    if (strobe.selShift) begin resVal = shiftVal; cyVal = shCy; end
  end

  assign result    = resVal;
  assign zeroFlag  = strobe.flagWe && (resVal == '0);
  assign signFlag  = strobe.flagWe && resVal[MSB];
  assign ovfFlag   = strobe.flagWe && ovVal;
  assign carryFlag = strobe.flagWe && cyVal;
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 5
) (
  input  logic [3:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             useImm,
  input  logic [IMM_W-1:0] imm,
  output logic [WIDTH-1:0] result,
  output logic             wrEn,
  output logic             flagWe,
  output logic             zeroFlag,
  output logic             signFlag,
  output logic             ovfFlag,
  output logic             carryFlag
);
  aluStrobe_t strobe;

  int_alu_ctrl u_ctrl (.opSel(opSel), .strobe(strobe));

  int_alu_dp #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_dp (
    .strobe(strobe), .opA(opA), .opB(opB), .useImm(useImm), .imm(imm),
    .result(result), .zeroFlag(zeroFlag), .signFlag(signFlag),
    .ovfFlag(ovfFlag), .carryFlag(carryFlag)
  );

  assign wrEn   = strobe.wrEn;
  assign flagWe = strobe.flagWe;
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 5
) (
  input logic [3:0]       opSel,
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             useImm,
  input logic [IMM_W-1:0] imm,
  input logic [WIDTH-1:0] result,
  input logic             wrEn,
  input logic             flagWe,
  input logic             zeroFlag,
  input logic             signFlag,
  input logic             ovfFlag,
  input logic             carryFlag
);
  localparam int SH_W = $clog2(WIDTH);
  logic known, isShift, isLogic;
  logic [SH_W-1:0] cnt;

  assign known   = !$isunknown({opSel, opA, opB, useImm, imm});
  assign isShift = (opSel >= 4'd8) && (opSel <= 4'd10);
  assign isLogic = (opSel >= 4'd4) && (opSel <= 4'd7);
  assign cnt     = useImm ? SH_W'(imm) : opA[SH_W-1:0];

  always_comb begin
    if (known) begin
      // R3: compare never writes the register file
      p_cmp_nowrite_r3: assert (!(opSel == 4'd3) || (!wrEn && flagWe));
      // R9: move leaves flags untouched and reads zero
      p_mov_noflags_r9: assert (!(opSel == 4'd0) || (!flagWe && wrEn && !zeroFlag && !carryFlag));
      // R6: shifts and logic never report overflow
      p_no_overflow_r6: assert (!(isShift || isLogic) || !ovfFlag);
      // R5: zero count gives no carry and passes the value through
      p_zero_count_r5: assert (!(isShift && cnt == '0) || (!carryFlag && result == opB));
      // R7: arithmetic right keeps the sign bit
      p_sar_sign_r7: assert (!(opSel == 4'd10) || (result[WIDTH-1] == opB[WIDTH-1]));
      // R10: zero and sign follow the result
      p_zs_follow_r10: assert (!flagWe || (zeroFlag == (result == '0) && signFlag == result[WIDTH-1]));
      // R11: undefined codes are inert
      p_undef_inert_r11: assert (!(opSel > 4'd10) || (!wrEn && !flagWe && result == '0));
    end
  end
endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/sim_int_alu.sv
module sim_int_alu;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] MOV = 0, ADD = 1, SUB = 2, CMP = 3, AND_ = 4, OR_ = 5,
                         XOR_ = 6, NOT_ = 7, SHL = 8, SHR = 9, SAR = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]  opSel = 4'd15;
  logic [31:0] opA = '0, opB = '0;
  logic        useImm = 1'b0;
  logic [4:0]  imm = '0;
  logic [31:0] result;
  logic        wrEn, flagWe, zeroFlag, signFlag, ovfFlag, carryFlag;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  int_alu u0 (.opSel(opSel), .opA(opA), .opB(opB), .useImm(useImm), .imm(imm),
              .result(result), .wrEn(wrEn), .flagWe(flagWe), .zeroFlag(zeroFlag),
              .signFlag(signFlag), .ovfFlag(ovfFlag), .carryFlag(carryFlag));

  // reference model: packed {res, wr, fw, z, s, v, c}
  function automatic logic [37:0] model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                         logic ui, logic [4:0] im);
    logic [31:0] s, r;
    logic [32:0] w;
    logic [63:0] t;
    longint sb, ss, sv;
    int n;
    logic wr, fw, v, c;
    s = ui ? ((op >= SHL && op <= SAR) ? {27'd0, im} : {{27{im[4]}}, im}) : a;
    n = int'(s[4:0]);
    r = 0; wr = 1; fw = 1; v = 0; c = 0;
    sb = longint'($signed(b)); ss = longint'($signed(s));
    case (op)
      MOV: begin r = s; fw = 0; end
      ADD: begin w = {1'b0, b} + {1'b0, s}; r = w[31:0]; c = w[32];
                 sv = sb + ss; v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648); end
      SUB, CMP: begin r = b - s; c = (b < s); sv = sb - ss;
                 v = (sv > 64'sd2147483647) || (sv < -64'sd2147483648); wr = (op == SUB); end
      AND_: r = b & s;
      OR_:  r = b | s;
      XOR_: r = b ^ s;
      NOT_: r = ~s;
      SHL: begin t = {32'd0, b} << n; r = t[31:0]; c = t[32]; end
      SHR: begin t = {b, 32'd0} >> n; r = t[63:32]; c = t[31]; end
      SAR: begin t = {b, 32'd0} >> n; r = 32'($signed(b) >>> n); c = t[31]; end
      default: begin wr = 0; fw = 0; end
    endcase
    if (!fw) return {r, wr, fw, 4'b0000};
    return {r, wr, fw, (r == 0), r[31], v, c};
  endfunction

  task automatic apply(string tag, logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic ui, logic [4:0] im);
    logic [37:0] exp, got;
    @(negedge clk);
    opSel = op; opA = a; opB = b; useImm = ui; imm = im;
    #1;
    exp = model(op, a, b, ui, im);
    got = {result, wrEn, flagWe, zeroFlag, signFlag, ovfFlag, carryFlag};
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s op=%0d a=%h b=%h imm=%0d/%0d actual=%h expected=%h",
               tag, op, a, b, ui, im, got, exp);
    end
  endtask

  task automatic t_idle;      // R11 undefined codes, initial state
    for (int k = 11; k < 16; k++) apply("R11", 4'(k), 32'hFFFF_FFFF, 32'h8000_0001, 1'b0, 5'd3);
  endtask
  task automatic t_add;       // R1
    apply("R1", ADD, 32'h0000_0001, 32'hFFFF_FFFF, 0, 0);
    apply("R1", ADD, 32'h0000_0001, 32'h7FFF_FFFF, 0, 0);
    apply("R1", ADD, 32'h8000_0000, 32'h8000_0000, 0, 0);
    apply("R1", ADD, 32'h1234_5678, 32'h1111_1111, 0, 0);
  endtask
  task automatic t_sub_cmp;   // R2 R3
    apply("R2", SUB, 32'h0000_0001, 32'h0000_0000, 0, 0);
    apply("R2", SUB, 32'h0000_0001, 32'h8000_0000, 0, 0);
    apply("R2", SUB, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 0, 0);
    apply("R3", CMP, 32'h0000_0005, 32'h0000_0005, 0, 0);
    apply("R3", CMP, 32'h0000_0006, 32'h0000_0005, 0, 0);
  endtask
  task automatic t_count;     // R4 upper count bits ignored
    apply("R4", SHL, 32'hFFFF_FFE3, 32'h0000_00F1, 0, 0);
    apply("R4", SHR, 32'h8000_0000, 32'hDEAD_BEEF, 0, 0);
    apply("R4", SAR, 32'h7FFF_FFE1, 32'h8000_0003, 0, 0);
  endtask
  task automatic t_carry;     // R5
    apply("R5", SHL, 32'd0,  32'hFFFF_FFFF, 0, 0);
    apply("R5", SHL, 32'd1,  32'h8000_0000, 0, 0);
    apply("R5", SHL, 32'd31, 32'h0000_0002, 0, 0);
    apply("R5", SHR, 32'd1,  32'h0000_0001, 0, 0);
    apply("R5", SHR, 32'd31, 32'h4000_0000, 0, 0);
    apply("R5", SAR, 32'd0,  32'h8000_0001, 0, 0);
  endtask
  task automatic t_ovclear;   // R6
    apply("R6", AND_, 32'h8000_0000, 32'h8000_0000, 0, 0);
    apply("R6", OR_,  32'h7FFF_FFFF, 32'h8000_0000, 0, 0);
    apply("R6", XOR_, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    apply("R6", NOT_, 32'h0000_0000, 32'h1234_0000, 0, 0);
    apply("R6", SHL,  32'd1,         32'h4000_0000, 0, 0);
  endtask
  task automatic t_sar;       // R7
    apply("R7", SAR, 32'd4,  32'hF000_0000, 0, 0);
    apply("R7", SAR, 32'd31, 32'h8000_0000, 0, 0);
    apply("R7", SHR, 32'd4,  32'hF000_0000, 0, 0);
  endtask
  task automatic t_imm;       // R8
    apply("R8", MOV, 32'h1234_5678, 32'd0, 1, 5'h10);
    apply("R8", ADD, 32'd0, 32'h0000_0001, 1, 5'h1F);
    apply("R8", CMP, 32'd0, 32'hFFFF_FFF0, 1, 5'h10);
    apply("R8", SHL, 32'hFFFF_FFFF, 32'h0000_0001, 1, 5'h1F);
    apply("R8", SHR, 32'h0, 32'h8000_0000, 1, 5'h10);
    apply("R8", AND_, 32'h0, 32'h0000_FFFF, 1, 5'h1E);
  endtask
  task automatic t_mov;       // R9
    apply("R9", MOV, 32'h0000_0000, 32'hFFFF_FFFF, 0, 0);
    apply("R9", MOV, 32'h8000_0000, 32'h0, 0, 0);
  endtask
  task automatic t_zs;        // R10
    apply("R10", ADD, 32'h0000_0001, 32'hFFFF_FFFF, 0, 0);
    apply("R10", XOR_, 32'h8000_0000, 32'h0, 0, 0);
    apply("R10", SUB, 32'h0000_0002, 32'h0000_0001, 0, 0);
  endtask
  task automatic t_random;    // R1 R2 R5 R8 R10 R11 mixed
    for (int k = 0; k < 2000; k++)
      apply("R10", 4'($urandom_range(0, 15)), $urandom, $urandom, 1'($urandom), 5'($urandom));
  endtask

  initial begin
    void'($urandom(32'd7));
    t_idle; t_add; t_sub_cmp; t_count; t_carry; t_ovclear;
    t_sar; t_imm; t_mov; t_zs; t_random;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule